// File: doc/BRIEF.md
# ARINC 429 Receive Word Filter

This block sits between the receive deserializers of an ARINC 429 receiver and its receive FIFOs. Each channel hands it complete 32-bit words; the block decides, in one clock, whether a word is written to that channel's FIFO. A word is kept only if it passes two checks, and each check can be switched off on its own. The first check compares the two source/destination bits (word bits 9 and 10) with programmed values. The second looks the 8-bit label (word bits 1 to 8) up in a 16-entry label table that belongs to the channel.

A single control word sets the per-channel options: the bit-rate choice, the label check enable, the SDI check enable and the two expected SDI bits. It also holds two global bits. One is a table-access mode, in which per-channel load strobes fill the label table in sequence and read strobes return it in sequence. The other is a loopback select, which feeds the local transmitter's true and complement serial outputs into every receiver input in place of the line. The block also makes a per-channel bit-clock tick for the deserializers, at the input clock divided by 10 or by 80.

Top module: `a429_rx_filter`

## Requirements
- R1: After reset, `fifo_we` and `bit_tick` are low, the control word is zero, and every label table entry reads back as 0x00.
- R2: `bit_tick[c]` pulses for one clock every 10 clocks when the channel's rate bit (control bit 2+5c) is 0, and every 80 clocks when it is 1.
- R3: With the channel's SDI enable (bit 4+5c) set, a word is dropped unless word bit 9 (`data[8]`) equals control bit 5+5c and word bit 10 (`data[9]`) equals control bit 6+5c.
- R4: With the SDI enable clear, the values of word bits 9 and 10 do not affect acceptance.
- R5: With the channel's label enable (bit 3+5c) set, a word is accepted only if its label `data[7:0]` equals one of the 16 stored entries in all 8 bits.
- R6: With the label enable clear, every label passes.
- R7: A word is accepted only when both checks pass; acceptance gives a one-clock `fifo_we[c]` pulse in the clock after `word_vld[c]`, with `fifo_wdata` equal to the word unchanged.
- R8: While the table-access bit (bit 0) is set, each `lbl_wr[c]` pulse writes `lbl_wdata` into the next entry of channel c, from entry 0 to 15 and then back to 0; with it clear, `lbl_wr` is ignored and the pointers return to entry 0.
- R9: While the table-access bit is set, each `lbl_rd[c]` pulse places the next entry of channel c, from 0 to 15 and back to 0, on `lbl_rdata` one clock later.
- R10: With the loopback bit (bit 1) set, every `ser_hi`/`ser_lo` equals `tx_hi`/`tx_lo`; with it clear, they follow `line_hi`/`line_lo` of their own channel.
- R11: Channels are independent: the words, settings and table of one channel never change acceptance on another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 2+5*NCH | Control word value |
| lbl_wr | input | NCH | Label table load strobe per channel |
| lbl_rd | input | NCH | Label table read strobe per channel |
| lbl_wdata | input | 8 | Label value to load |
| lbl_rdata | output | 8*NCH | Label read data per channel |
| line_hi | input | NCH | Line receiver true output per channel |
| line_lo | input | NCH | Line receiver complement output per channel |
| tx_hi | input | 1 | Local transmitter true serial output |
| tx_lo | input | 1 | Local transmitter complement serial output |
| ser_hi | output | NCH | Selected true input to each deserializer |
| ser_lo | output | NCH | Selected complement input to each deserializer |
| bit_tick | output | NCH | Bit clock enable per channel |
| word_vld | input | NCH | Complete word present, per channel |
| word_data | input | 32*NCH | Received words |
| fifo_we | output | NCH | Receive FIFO write pulse per channel |
| fifo_wdata | output | 32*NCH | Word written to the FIFO |

## Verification
A wrong control value or a faulty SDI or label compare shows on the very next offered word: `fifo_we` rises or stays low one clock after `word_vld` against the expectation. A slipped table write or read pointer stays hidden until the table is read back, where it shows as entries out of order or a wrong wrap value; it also shows as a label that should match being refused. A rate counter fault shows within one tick period as a gap other than 10 or 80 clocks.

// File: rtl/a429f_pkg.sv
`timescale 1ns/1ps
// Shared constants and the per-channel control field type.
// Assumes word bit 1 is data[0]; the label is data[7:0], SDI is data[9:8].
package a429f_pkg;
    localparam int WORD_W     = 32;
    localparam int LBL_W      = 8;
    localparam int SDI_LO_BIT = 8;   // word bit 9
    localparam int SDI_HI_BIT = 9;   // word bit 10
    localparam int CFG_MODE   = 0;   // label table access mode
    localparam int CFG_LOOP   = 1;   // loopback select
    localparam int CFG_CH_BASE = 2;
    localparam int CFG_CH_W    = 5;

    // Per-channel control, LSB first: slow, lbl_en, sdi_en, sdi9, sdi10
    typedef struct packed {
        logic sdi10;
        logic sdi9;
        logic sdi_en;
        logic lbl_en;
        logic slow;
    } ch_cfg_t;
endpackage

// File: rtl/a429_rate_gen.sv
`timescale 1ns/1ps
// Bit clock enable for one receive channel: a one-clock tick every
// DIV_FAST clocks, or every DIV_SLOW clocks when 'slow' is set.
// Assumes DIV_FAST >= 2 and DIV_SLOW >= DIV_FAST.
module a429_rate_gen #(
    parameter int DIV_FAST = 10,
    parameter int DIV_SLOW = 80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow,
    output logic tick
);
    localparam int CNT_W = $clog2(DIV_SLOW);
    localparam logic [CNT_W-1:0] LAST_FAST = CNT_W'(DIV_FAST - 1);
    localparam logic [CNT_W-1:0] LAST_SLOW = CNT_W'(DIV_SLOW - 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;

    // Pick the terminal count for the selected rate.
    always_comb last = slow ? LAST_SLOW : LAST_FAST;

    // Count clocks and emit a tick at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= last) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end

    // R2
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST_SLOW);
endmodule

// File: rtl/a429_label_cam.sv
`timescale 1ns/1ps
// Label table of one channel: DEPTH entries compared in parallel with the
// incoming label; loaded and read back in sequence while 'mode' is set.
// Assumes strobes are one clock wide; pointers rest at entry 0 outside mode.
module a429_label_cam #(
    parameter int DEPTH = 16,
    parameter int LW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode,
    input  logic          wr,
    input  logic          rd,
    input  logic [LW-1:0] wdata,
    input  logic [LW-1:0] lbl_in,
    output logic          hit,
    output logic [LW-1:0] rdata
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [LW-1:0]    mem [DEPTH];
    logic [PTR_W-1:0] wptr;
    logic [PTR_W-1:0] rptr;

    // Write entries in sequence while in table-access mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            wptr <= '0;
        end else if (!mode) begin
            wptr <= '0;
        end else if (wr) begin
            mem[wptr] <= wdata;
            wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
        end
    end

    // Read entries in sequence while in table-access mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr  <= '0;
            rdata <= '0;
        end else if (!mode) begin
            rptr <= '0;
        end else if (rd) begin
            rdata <= mem[rptr];
            rptr  <= (rptr == LAST) ? '0 : rptr + 1'b1;
        end
    end

    // Compare the incoming label with every entry at once.
    always_comb begin
        hit = 1'b0;
        for (int i = 0; i < DEPTH; i++) hit = hit | (mem[i] == lbl_in);
    end

    // R8
    wptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode && wr && wptr == LAST) |=> wptr == '0);
    // R9
    rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mode && rd) |=> $stable(rdata));
endmodule

// File: rtl/a429_word_check.sv
`timescale 1ns/1ps
// Acceptance decision for one channel: SDI compare and label table hit,
// each bypassable; an accepted word gives a one-clock FIFO write.
// Assumes lbl_hit is the table result for word_data's label this clock.
module a429_word_check
    import a429f_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  ch_cfg_t           cfg,
    input  logic              lbl_hit,
    input  logic              word_vld,
    input  logic [WORD_W-1:0] word_data,
    output logic              fifo_we,
    output logic [WORD_W-1:0] fifo_wdata
);
    logic sdi_ok;
    logic lbl_ok;

    // SDI check: both bits must match when enabled.
    always_comb sdi_ok = !cfg.sdi_en ||
        ((word_data[SDI_LO_BIT] == cfg.sdi9) && (word_data[SDI_HI_BIT] == cfg.sdi10));

    // Label check: a table hit is needed when enabled.
    always_comb lbl_ok = !cfg.lbl_en || lbl_hit;

    // Register the decision and the word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_we    <= 1'b0;
            fifo_wdata <= '0;
        end else begin
            fifo_we <= word_vld && sdi_ok && lbl_ok;
            if (word_vld) fifo_wdata <= word_data;
        end
    end

    // R7
    accept_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_we |-> $past(word_vld));
    // R7
    data_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_we |-> fifo_wdata == $past(word_data));
    // R3
    sdi_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_we && $past(cfg.sdi_en)) |->
            fifo_wdata[SDI_HI_BIT:SDI_LO_BIT] == {$past(cfg.sdi10), $past(cfg.sdi9)});
    // R5
    label_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_we && $past(cfg.lbl_en)) |-> $past(lbl_hit));
endmodule

// File: rtl/a429_rx_filter.sv
`timescale 1ns/1ps
// ARINC 429 receive word filter for NCH channels: control word, loopback
// select, bit clock enables, per-channel label tables and acceptance.
// Assumes one complete word per word_vld pulse from each deserializer.
module a429_rx_filter
    import a429f_pkg::*;
#(
    parameter int NCH      = 2,
    parameter int DEPTH    = 16,
    parameter int DIV_FAST = 10,
    parameter int DIV_SLOW = 80,
    localparam int CTRL_W  = CFG_CH_BASE + CFG_CH_W * NCH
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [CTRL_W-1:0]     cfg_wdata,
    input  logic [NCH-1:0]        lbl_wr,
    input  logic [NCH-1:0]        lbl_rd,
    input  logic [LBL_W-1:0]      lbl_wdata,
    output logic [NCH*LBL_W-1:0]  lbl_rdata,
    input  logic [NCH-1:0]        line_hi,
    input  logic [NCH-1:0]        line_lo,
    input  logic                  tx_hi,
    input  logic                  tx_lo,
    output logic [NCH-1:0]        ser_hi,
    output logic [NCH-1:0]        ser_lo,
    output logic [NCH-1:0]        bit_tick,
    input  logic [NCH-1:0]        word_vld,
    input  logic [NCH*WORD_W-1:0] word_data,
    output logic [NCH-1:0]        fifo_we,
    output logic [NCH*WORD_W-1:0] fifo_wdata
);
    logic [CTRL_W-1:0] ctrl_q;

    // Hold the control word.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctrl_q <= '0;
        else if (cfg_we) ctrl_q <= cfg_wdata;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        ch_cfg_t           cc;
        logic              hit;
        logic [WORD_W-1:0] w;

        // Slice this channel's fields and word.
        assign cc = ch_cfg_t'(ctrl_q[CFG_CH_BASE + c*CFG_CH_W +: CFG_CH_W]);
        assign w  = word_data[c*WORD_W +: WORD_W];

        // Route transmitter outputs to the receiver in loopback.
        assign ser_hi[c] = ctrl_q[CFG_LOOP] ? tx_hi : line_hi[c];
        assign ser_lo[c] = ctrl_q[CFG_LOOP] ? tx_lo : line_lo[c];

        a429_rate_gen #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_rate (
            .clk   (clk),
            .rst_n (rst_n),
            .slow  (cc.slow),
            .tick  (bit_tick[c])
        );

        a429_label_cam #(.DEPTH(DEPTH), .LW(LBL_W)) u_cam (
            .clk    (clk),
            .rst_n  (rst_n),
            .mode   (ctrl_q[CFG_MODE]),
            .wr     (lbl_wr[c]),
            .rd     (lbl_rd[c]),
            .wdata  (lbl_wdata),
            .lbl_in (w[LBL_W-1:0]),
            .hit    (hit),
            .rdata  (lbl_rdata[c*LBL_W +: LBL_W])
        );

        a429_word_check u_chk (
            .clk        (clk),
            .rst_n      (rst_n),
            .cfg        (cc),
            .lbl_hit    (hit),
            .word_vld   (word_vld[c]),
            .word_data  (w),
            .fifo_we    (fifo_we[c]),
            .fifo_wdata (fifo_wdata[c*WORD_W +: WORD_W])
        );
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (fifo_we == '0) && (bit_tick == '0));
endmodule

// File: tb/sim_a429_rx_filter.sv
`timescale 1ns/1ps
module sim_a429_rx_filter;
    localparam int NCH = 2;
    localparam int CW  = 2 + 5*NCH;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [CW-1:0]     cfg_wdata = '0;
    logic [NCH-1:0]    lbl_wr = '0, lbl_rd = '0;
    logic [7:0]        lbl_wdata = '0;
    logic [NCH*8-1:0]  lbl_rdata;
    logic [NCH-1:0]    line_hi = '0, line_lo = '0;
    logic              tx_hi = 1'b0, tx_lo = 1'b0;
    logic [NCH-1:0]    ser_hi, ser_lo, bit_tick, fifo_we;
    logic [NCH-1:0]    word_vld = '0;
    logic [NCH*32-1:0] word_data = '0;
    logic [NCH*32-1:0] fifo_wdata;

    int checks = 0, fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    a429_rx_filter u0 (.*);

    typedef struct packed { logic ch; logic [31:0] w; logic acc; } vec_t;
    // ch0: SDI on (bit9=1, bit10=0), labels on; ch1: both checks off
    localparam vec_t VEC [10] = '{
        '{1'b0, 32'h0000_0120, 1'b1},   // R5 first entry, R3 match
        '{1'b0, 32'h0000_012F, 1'b1},   // R5 last entry
        '{1'b0, 32'h0000_0130, 1'b0},   // R5 miss
        '{1'b0, 32'h0000_0020, 1'b0},   // R3 bit9 wrong
        '{1'b0, 32'h0000_0320, 1'b0},   // R3 bit10 wrong
        '{1'b0, 32'h0000_01A0, 1'b0},   // R5 only MSB differs
        '{1'b0, 32'h0000_0220, 1'b0},   // R3 both wrong
        '{1'b1, 32'h0000_0355, 1'b1},   // R6/R4 ch1 open
        '{1'b1, 32'hABCD_0200, 1'b1},   // R4 ch1 open
        '{1'b0, 32'hFFFF_FD27, 1'b1}    // R7 upper bits carried
    };

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [4:0] chb(logic slow, logic le, logic se, logic b9, logic b10);
        return {b10, b9, se, le, slow};
    endfunction

    task automatic set_cfg(logic [CW-1:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic load(int ch, logic [7:0] v);
        @(negedge clk); lbl_wr[ch] = 1'b1; lbl_wdata = v;
        @(negedge clk); lbl_wr[ch] = 1'b0;
    endtask

    task automatic readl(int ch, output logic [7:0] v);
        @(negedge clk); lbl_rd[ch] = 1'b1;
        @(negedge clk); lbl_rd[ch] = 1'b0;
        v = lbl_rdata[ch*8 +: 8];
    endtask

    // Offer one word and check the FIFO write in the following clock.
    task automatic send(string req, int ch, logic [31:0] w, logic acc);
        @(negedge clk); word_vld[ch] = 1'b1; word_data[ch*32 +: 32] = w;
        @(negedge clk); word_vld = '0;
        chk(req, {31'd0, fifo_we[ch]}, {31'd0, acc});
        chk({req, " other channel quiet"}, {31'd0, fifo_we[1-ch]}, 32'd0);
        if (acc) chk({req, " data"}, fifo_wdata[ch*32 +: 32], w);
        @(negedge clk);
        chk({req, " single pulse"}, {31'd0, fifo_we[ch]}, 32'd0);
    endtask

    task automatic gap(int ch, output int n);
        int k = 0;
        while (!bit_tick[ch] && k < 300) begin @(negedge clk); k++; end
        n = 0;
        do begin @(negedge clk); n++; end while (!bit_tick[ch] && n < 300);
    endtask

    initial begin
        logic [7:0] rv;
        int n;
        repeat (3) @(negedge clk);
        chk("R1 fifo_we at reset", {30'd0, fifo_we}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 fifo_we after reset", {30'd0, fifo_we}, 32'd0);
        chk("R1 bit_tick after reset", {30'd0, bit_tick}, 32'd0);

        // R8 load ch0: 0x5A, 0x21..0x2F, then wrap write 0x20 into entry 0
        set_cfg(12'h001);
        readl(1, rv);
        chk("R1 ch1 entry0 after reset", {24'd0, rv}, 32'h00);
        load(0, 8'h5A);
        for (int i = 1; i < 16; i++) load(0, 8'h20 + 8'(i));
        load(0, 8'h20);
        set_cfg(12'h000);
        load(0, 8'h77);   // R8 ignored outside table mode

        set_cfg({chb(1,0,0,0,0), chb(0,1,1,1,0), 1'b0, 1'b0});
        for (int i = 0; i < 10; i++)
            send($sformatf("R7 vector %0d", i), int'(VEC[i].ch), VEC[i].w, VEC[i].acc);

        // R4: ch0 SDI off, labels on
        set_cfg({chb(1,0,0,0,0), chb(0,1,0,0,0), 1'b0, 1'b0});
        send("R4 sdi off any bits", 0, 32'h0000_0325, 1'b1);
        send("R5 label miss with sdi off", 0, 32'h0000_0330, 1'b0);
        // R6: ch0 labels off, SDI on with bit9=0 bit10=1
        set_cfg({chb(1,0,0,0,0), chb(0,0,1,0,1), 1'b0, 1'b0});
        send("R6 any label passes", 0, 32'h0000_0299, 1'b1);
        send("R3 sdi mismatch", 0, 32'h0000_0199, 1'b0);

        // R11: both channels at once, ch1 with labels on (table all zero)
        set_cfg({chb(1,1,0,0,0), chb(0,0,0,0,0), 1'b0, 1'b0});
        @(negedge clk); word_vld = 2'b11;
        word_data = {32'h0000_0020, 32'h0000_0044};
        @(negedge clk); word_vld = '0;
        chk("R11 ch0 accepts", {31'd0, fifo_we[0]}, 32'd1);
        chk("R11 ch1 own table rejects", {31'd0, fifo_we[1]}, 32'd0);
        send("R11 ch1 label 0x00 in reset table", 1, 32'h0000_0100, 1'b1);

        // R2 rates: ch0 fast, ch1 slow
        gap(0, n); chk("R2 fast period", n, 32'd10);
        gap(1, n); chk("R2 slow period", n, 32'd80);

        // R9 readback, wrap, and R8 outcomes
        set_cfg(12'h001);
        for (int i = 0; i < 16; i++) begin
            readl(0, rv);
            chk($sformatf("R9 entry %0d", i), {24'd0, rv}, (i == 0) ? 32'h20 : 32'h20 + 32'(i));
        end
        readl(0, rv);
        chk("R9 read wraps to entry 0", {24'd0, rv}, 32'h20);
        @(negedge clk); lbl_rd[1] = 1'b0;
        chk("R9 rdata held without strobe", {24'd0, lbl_rdata[7:0]}, 32'h20);

        // R10 loopback
        line_hi = 2'b00; line_lo = 2'b11; tx_hi = 1'b1; tx_lo = 1'b0;
        set_cfg(12'h000);
        chk("R10 off hi", {30'd0, ser_hi}, 32'd0);
        chk("R10 off lo", {30'd0, ser_lo}, 32'd3);
        set_cfg(12'h002);
        chk("R10 on hi", {30'd0, ser_hi}, 32'd3);
        chk("R10 on lo", {30'd0, ser_lo}, 32'd0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule